// File: doc/BRIEF.md
# Text-Mode Character Pixel Generator

This block turns a screen coordinate into a 24-bit colour for a character-cell text display. For each requested pixel it locates the character cell and the scanline within it. It fetches the 16-bit character word from character memory and the glyph row byte from font memory. It picks foreground or background, maps that choice through the attribute palette and the colour DAC, and widens the DAC's 6-bit components to 8 bits. A block cursor is laid over one cell. Two more cases give black: pixels outside the active text area, and the display-off state.

The cell geometry comes from register-style configuration inputs. The cell is 8 or 9 dots wide. The cell height is 1 to 32 scanlines. The visible column count and the vertical display end set the active area. Start address and row pitch locate the text rows in character memory. The three memories sit outside the block. Each is reached through an address output and a read-data input that returns data one clock after the address. Requests may arrive on every cycle, and results come out in order after a fixed latency.

Top module: `text_pixel_gen`

## Requirements
- R1: A request accepted with `px_valid` high yields `pix_valid` high exactly 4 clock edges later, in request order. After reset `pix_valid` is 0 and `pix_rgb` is 0.
- R2: Let col = x / cell width and row = y / cell height. The character word is read at byte address (0x18000 + 2*{start_hi,start_lo} + row*4*row_pitch + 2*col) mod 2^17. Bits 7:0 of the word are the character code and bits 15:8 are the attribute.
- R3: The glyph byte is read at font address 32*code + (y mod cell height). Bit 7 of that byte is the leftmost dot. A set bit selects the foreground palette entry, attribute bits 3:0. A clear bit selects the background entry, attribute bits 7:4.
- R4: The cell width is 8 when `narrow_cells` is 1 and 9 when it is 0. The cell height is `cell_h_m1` + 1.
- R5: In 9-wide cells, the ninth dot copies glyph bit 0 when `line_gfx_en` is 1 and the code lies in 0xB0..0xDF inclusive. Otherwise the ninth dot is background.
- R6: Palette entry i is `pal_regs[6i+5:6i]`. The DAC index is {color_sel[3:0], entry[3:0]} when `pal_sub16` is 1, and {color_sel[3:2], entry[5:0]} when it is 0.
- R7: `dac_rdata` is {R[17:12], G[11:6], B[5:0]}. Each 6-bit component v becomes the 8-bit value {v, v[0], v[0]}. `pix_rgb` is {R[23:16], G[15:8], B[7:0]}.
- R8: The cursor cell has unmasked address 0x18000 + 2*{curs_hi,curs_lo}, compared before the 17-bit wrap. In that cell the cursor shows foreground on every dot, the ninth included, on scanlines curs_top[4:0] through min(curs_bot, height-1). No cursor is drawn when curs_top[5] is 1, when that end is below the start, or when the start is not below the height.
- R9: A pixel is black (0) when x >= (cols_m1+1)*width or y >= rows*height. Here rows = (vde+1)/height and vde = {vde_hi[1], vde_hi[0], vde_lo}.
- R10: Every pixel is black (0) while `display_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| px_valid | input | 1 | Pixel request strobe |
| px_x | input | 12 | Pixel column |
| px_y | input | 12 | Pixel scanline |
| display_en | input | 1 | 0 forces black output |
| narrow_cells | input | 1 | 1: 8-dot cells, 0: 9-dot cells |
| cell_h_m1 | input | 5 | Cell height minus one |
| cols_m1 | input | 8 | Visible columns minus one |
| vde_lo | input | 8 | Vertical display end, bits 7:0 |
| vde_hi | input | 2 | Vertical display end, bits 9:8 |
| start_hi | input | 8 | Text start address, high byte |
| start_lo | input | 8 | Text start address, low byte |
| row_pitch | input | 8 | Row advance in units of 4 bytes |
| curs_hi | input | 8 | Cursor location, high byte |
| curs_lo | input | 8 | Cursor location, low byte |
| curs_top | input | 6 | Bit 5 hides cursor, bits 4:0 first scanline |
| curs_bot | input | 5 | Last cursor scanline |
| line_gfx_en | input | 1 | Enables ninth-dot copy for line-graphics codes |
| pal_sub16 | input | 1 | Selects the 4+4 DAC index form |
| color_sel | input | 4 | Colour select bits for the DAC index |
| pal_regs | input | 96 | Sixteen 6-bit palette entries |
| vram_addr | output | 17 | Character memory byte address |
| vram_rdata | input | 16 | Character word, one cycle after address |
| font_addr | output | 13 | Font memory byte address |
| font_rdata | input | 8 | Glyph row byte, one cycle after address |
| dac_addr | output | 8 | DAC entry index |
| dac_rdata | input | 18 | DAC entry, one cycle after address |
| pix_valid | output | 1 | Output pixel strobe |
| pix_rgb | output | 24 | Output colour |

## Verification
The hardest case to reach is a ninth-dot or cursor pixel whose foreground and background differ. The character and glyph memories hold hashed contents, so a random sweep rarely lands on a line-graphics code with glyph bit 0 set, or on a cursor cell with distinct attribute nibbles. The bench plants one chosen character word at a computed cell address and one chosen glyph byte at its font address. Each scenario then drives the pixels of that cell. The cursor cases cover clipping to the height, an inverted range, a start past the height, the hide bit, and a start address whose cell wraps past the 17-bit boundary while the cursor still matches on the unwrapped address.

// File: rtl/text_pixel_gen.sv
module text_pixel_gen #(
  parameter int XW = 12,
  parameter int YW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          px_valid,
  input  logic [XW-1:0] px_x,
  input  logic [YW-1:0] px_y,
  input  logic          display_en,
  input  logic          narrow_cells,
  input  logic [4:0]    cell_h_m1,
  input  logic [7:0]    cols_m1,
  input  logic [7:0]    vde_lo,
  input  logic [1:0]    vde_hi,
  input  logic [7:0]    start_hi,
  input  logic [7:0]    start_lo,
  input  logic [7:0]    row_pitch,
  input  logic [7:0]    curs_hi,
  input  logic [7:0]    curs_lo,
  input  logic [5:0]    curs_top,
  input  logic [4:0]    curs_bot,
  input  logic          line_gfx_en,
  input  logic          pal_sub16,
  input  logic [3:0]    color_sel,
  input  logic [95:0]   pal_regs,
  output logic [16:0]   vram_addr,
  input  logic [15:0]   vram_rdata,
  output logic [12:0]   font_addr,
  input  logic [7:0]    font_rdata,
  output logic [7:0]    dac_addr,
  input  logic [17:0]   dac_rdata,
  output logic          pix_valid,
  output logic [23:0]   pix_rgb
);
  localparam int UW = 24;
  localparam logic [UW-1:0] TEXT_BASE = UW'(20'h18000);

  // stage 0: geometry and character address
  logic [3:0]    cw;
  logic [5:0]    ch;
  logic [XW-1:0] cx;
  logic [YW-1:0] cy;
  logic [3:0]    dot;
  logic [4:0]    ln;
  logic [10:0]   rows;
  logic          vis;
  logic [UW-1:0] ua, cur_ua;

  assign cw   = narrow_cells ? 4'd8 : 4'd9;
  assign ch   = {1'b0, cell_h_m1} + 6'd1;
  assign cx   = narrow_cells ? (px_x >> 3) : (px_x / XW'(9));
  assign dot  = 4'(px_x - XW'(cx * XW'(cw)));
  assign cy   = px_y / YW'(ch);
  assign ln   = 5'(px_y - YW'(cy * YW'(ch)));
  assign rows = ({1'b0, vde_hi, vde_lo} + 11'd1) / 11'(ch);
  assign vis  = (cx <= XW'(cols_m1)) && (int'(cy) < int'(rows));

  assign ua = TEXT_BASE + UW'({start_hi, start_lo, 1'b0})
            + UW'(cy) * UW'({row_pitch, 2'b00}) + UW'({cx, 1'b0});
  assign cur_ua = TEXT_BASE + UW'({curs_hi, curs_lo, 1'b0});
  assign vram_addr = ua[16:0];

  logic       v1, cur1, blank1;
  logic [3:0] dot1;
  logic [4:0] ln1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v1 <= 1'b0; cur1 <= 1'b0; blank1 <= 1'b1; dot1 <= '0; ln1 <= '0;
    end else begin
      v1     <= px_valid;
      cur1   <= (ua == cur_ua);
      blank1 <= !display_en || !vis;
      dot1   <= dot;
      ln1    <= ln;
    end
  end

  // stage 1: character word back, fetch glyph row
  assign font_addr = {vram_rdata[7:0], ln1};

  logic       v2, cur2, blank2;
  logic [3:0] dot2;
  logic [4:0] ln2;
  logic [7:0] code2, attr2;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v2 <= 1'b0; cur2 <= 1'b0; blank2 <= 1'b1; dot2 <= '0; ln2 <= '0;
      code2 <= '0; attr2 <= '0;
    end else begin
      v2     <= v1;
      cur2   <= cur1;
      blank2 <= blank1;
      dot2   <= dot1;
      ln2    <= ln1;
      code2  <= vram_rdata[7:0];
      attr2  <= vram_rdata[15:8];
    end
  end

  // stage 2: glyph row back, choose colour, fetch DAC entry
  logic       line_code, g_bit, curs_on, fg;
  logic [4:0] ce_eff;
  logic [3:0] idx;
  logic [5:0] pe;

  assign line_code = (code2 >= 8'hB0) && (code2 <= 8'hDF);
  assign g_bit = dot2[3] ? (line_gfx_en && line_code && font_rdata[0])
                         : font_rdata[3'd7 - dot2[2:0]];
  assign ce_eff  = (curs_bot < cell_h_m1) ? curs_bot : cell_h_m1;
  assign curs_on = cur2 && !curs_top[5] && (curs_top[4:0] <= cell_h_m1)
                && (ln2 >= curs_top[4:0]) && (ln2 <= ce_eff);
  assign fg  = g_bit || curs_on;
  assign idx = fg ? attr2[3:0] : attr2[7:4];
  assign pe  = pal_regs[int'(idx)*6 +: 6];
  assign dac_addr = pal_sub16 ? {color_sel, pe[3:0]} : {color_sel[3:2], pe};

  logic v3, blank3;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v3 <= 1'b0; blank3 <= 1'b1;
    end else begin
      v3 <= v2; blank3 <= blank2;
    end
  end

  // stage 3: widen DAC components
  logic [5:0] r6, g6, b6;
  assign {r6, g6, b6} = dac_rdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pix_valid <= 1'b0;
      pix_rgb   <= '0;
    end else begin
      pix_valid <= v3;
      pix_rgb   <= blank3 ? 24'h0 :
                   {r6, r6[0], r6[0], g6, g6[0], g6[0], b6, b6[0], b6[0]};
    end
  end

  a_r1_valid_origin: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |-> $past(px_valid, 4));

  a_r10_blank_black: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && !$past(display_en, 4)) |-> (pix_rgb == 24'h0));

  a_r6_sel_sub16: assert property (@(posedge clk) disable iff (!rst_n)
    (v2 && pal_sub16) |-> (dac_addr[7:4] == color_sel));

  a_r6_sel_wide: assert property (@(posedge clk) disable iff (!rst_n)
    (v2 && !pal_sub16) |-> (dac_addr[7:6] == color_sel[3:2]));
endmodule

// File: tb/text_pixel_gen_test.sv
module text_pixel_gen_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic px_valid = 0;
  logic [11:0] px_x = 0, px_y = 0;
  logic display_en = 1, narrow_cells = 1, line_gfx_en = 1, pal_sub16 = 0;
  logic [4:0] cell_h_m1 = 15, curs_bot = 15;
  logic [7:0] cols_m1 = 79, vde_lo = 8'h8F, start_hi = 0, start_lo = 0;
  logic [7:0] row_pitch = 40, curs_hi = 0, curs_lo = 5;
  logic [1:0] vde_hi = 2'b01;
  logic [5:0] curs_top = 6'h0E;
  logic [3:0] color_sel = 4'b1010;
  logic [95:0] pal_regs;
  logic [16:0] vram_addr; logic [15:0] vram_rdata = 0;
  logic [12:0] font_addr; logic [7:0] font_rdata = 0;
  logic [7:0] dac_addr;   logic [17:0] dac_rdata = 0;
  logic pix_valid; logic [23:0] pix_rgb;

  logic [16:0] sp_addr = 17'h1FFFF; logic [15:0] sp_word = 0;
  logic [12:0] sp_faddr = 13'h1FFF;  logic [7:0] sp_font = 0;

  int cyc = 0, checks = 0, fails = 0;
  string qtag[$]; logic [23:0] qrgb[$]; int qdue[$]; int qx[$]; int qy[$];

  text_pixel_gen uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [15:0] vmem(logic [16:0] a);
    if (a == sp_addr) return sp_word;
    return {a[8:1] ^ a[16:9] ^ 8'h5B, a[8:1] + 8'h21};
  endfunction
  function automatic logic [7:0] fmem(logic [12:0] a);
    if (a == sp_faddr) return sp_font;
    if (a[12:5] == 8'h00) return 8'h00;
    return 8'(a[7:0] * 8'd43) ^ {3'b000, a[12:8]};
  endfunction
  function automatic logic [17:0] dmem(logic [7:0] i);
    return {i[7:2], i[5:0] ^ 6'h2A, ~i[5:0]};
  endfunction
  function automatic logic [7:0] ex(logic [5:0] v);
    return {v, v[0], v[0]};
  endfunction

  always @(posedge clk) begin
    vram_rdata <= vmem(vram_addr);
    font_rdata <= fmem(font_addr);
    dac_rdata  <= dmem(dac_addr);
  end

  function automatic int cell_ua(int cx, int cy);
    return 'h18000 + 2 * {start_hi, start_lo} + cy * row_pitch * 4 + 2 * cx;
  endfunction

  function automatic logic [23:0] model(int x, int y);
    int cw, h, vde, rows, cols, cx, dot, cy, ln, ua, cs, ce;
    logic [15:0] w; logic [7:0] code, at, g; logic on;
    logic [3:0] idx; logic [5:0] pe; logic [7:0] di; logic [17:0] d;
    cw = narrow_cells ? 8 : 9;
    h = cell_h_m1 + 1;
    vde = {vde_hi, vde_lo};
    rows = (vde + 1) / h;
    cols = cols_m1 + 1;
    if (!display_en) return 24'h0;
    if (x >= cols * cw || y >= rows * h) return 24'h0;
    cx = x / cw; dot = x % cw; cy = y / h; ln = y % h;
    ua = cell_ua(cx, cy);
    w = vmem(17'(ua & 'h1FFFF));
    code = w[7:0]; at = w[15:8];
    g = fmem(13'(code * 32 + ln));
    if (dot < 8) on = g[7 - dot];
    else on = line_gfx_en && code >= 8'hB0 && code <= 8'hDF && g[0];
    cs = curs_top[4:0];
    ce = (curs_bot < h - 1) ? int'(curs_bot) : h - 1;
    if (ua == 'h18000 + 2 * {curs_hi, curs_lo} && !curs_top[5] &&
        ce >= cs && cs < h && ln >= cs && ln <= ce) on = 1;
    idx = on ? at[3:0] : at[7:4];
    pe = pal_regs[int'(idx)*6 +: 6];
    di = pal_sub16 ? {color_sel, pe[3:0]} : {color_sel[3:2], pe};
    d = dmem(di);
    return {ex(d[17:12]), ex(d[11:6]), ex(d[5:0])};
  endfunction

  task automatic px(input string tag, input int x, input int y);
    @(negedge clk);
    px_valid = 1; px_x = 12'(x); px_y = 12'(y);
    qtag.push_back(tag); qrgb.push_back(model(x, y));
    qdue.push_back(cyc + 4); qx.push_back(x); qy.push_back(y);
  endtask

  task automatic drain();
    @(negedge clk);
    px_valid = 0;
    wait (qtag.size() == 0);
    repeat (2) @(negedge clk);
  endtask

  task automatic plant(input int cx, input int cy, input logic [15:0] word,
                       input int ln, input logic [7:0] fbyte);
    sp_addr = 17'(cell_ua(cx, cy) & 'h1FFFF);
    sp_word = word;
    sp_faddr = 13'(word[7:0] * 32 + ln);
    sp_font = fbyte;
  endtask

  always @(negedge clk) begin
    if (rst_n && pix_valid) begin
      checks++;
      if (qtag.size() == 0) begin
        fails++;
        $display("FAIL R1 unexpected output rgb %h expected no output", pix_rgb);
      end else begin
        string t; logic [23:0] e; int due, x, y;
        t = qtag.pop_front(); e = qrgb.pop_front(); due = qdue.pop_front();
        x = qx.pop_front(); y = qy.pop_front();
        if (pix_rgb !== e || cyc != due) begin
          fails++;
          $display("FAIL %s pixel(%0d,%0d): rgb %h expected %h, cycle %0d expected %0d",
                   t, x, y, pix_rgb, e, cyc, due);
        end
      end
    end
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, got hang expected completion");
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) pal_regs[i*6 +: 6] = 6'((i * 7 + 3) & 63);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    checks++;
    if (pix_valid !== 1'b0 || pix_rgb !== 24'h0) begin
      fails++;
      $display("FAIL R1 reset state: valid %b rgb %h expected 0 000000", pix_valid, pix_rgb);
    end

    // R3 R4 R7: 8-wide dots across two cells, back to back
    for (int x = 0; x < 16; x++) px("R3", x, 3);
    // R2: scattered cells over several rows
    px("R2", 8*3+2, 16*7+5); px("R2", 8*70+7, 16*24+15); px("R2", 8*11, 16*1);
    // R8: cursor cell lines 14,15 on, 13 off
    drain();
    plant(5, 0, 16'h1E00, 0, 8'h00);
    for (int x = 40; x < 48; x++) px("R8", x, 14);
    px("R8", 41, 15); px("R8", 41, 13);
    drain();

    // R6: 4+4 palette form with another colour select
    pal_sub16 = 1; color_sel = 4'b0110;
    for (int x = 100; x < 110; x++) px("R6", x, 33);
    drain();
    pal_sub16 = 0; color_sel = 4'b1010;

    // R4 R7: 9-wide cells
    narrow_cells = 0;
    for (int x = 0; x < 18; x++) px("R4", x, 20);
    drain();

    // R5: ninth dot copy for line-graphics codes
    plant(2, 1, 16'h1EC4, 3, 8'h01);
    px("R5", 26, 19); px("R5", 25, 19); drain();
    plant(2, 1, 16'h1EDF, 3, 8'h01); px("R5", 26, 19); drain();
    plant(2, 1, 16'h1EB0, 3, 8'h01); px("R5", 26, 19); drain();
    plant(2, 1, 16'h1EAF, 3, 8'h01); px("R5", 26, 19); drain();
    plant(2, 1, 16'h1EE0, 3, 8'h01); px("R5", 26, 19); drain();
    line_gfx_en = 0;
    plant(2, 1, 16'h1EC4, 3, 8'h01); px("R5", 26, 19); drain();
    line_gfx_en = 1;

    // R8: cursor corner cases, height 8, 9-wide including ninth dot
    cell_h_m1 = 7;
    plant(5, 0, 16'h1E00, 0, 8'h00);
    curs_top = 6'h05; curs_bot = 5'h1F;
    for (int y = 4; y < 8; y++) px("R8", 45 + 8, y);
    px("R8", 45, 6);
    drain();
    curs_top = 6'h25; px("R8", 53, 6); drain();
    curs_top = 6'h0A; curs_bot = 5'h05; px("R8", 53, 6); drain();
    curs_top = 6'h09; curs_bot = 5'h1F; px("R8", 53, 7); drain();
    curs_top = 6'h03; curs_bot = 5'h03;
    px("R8", 53, 3); px("R8", 53, 2); px("R8", 53, 4); drain();

    // R2 R8: start address wraps past the 17-bit boundary
    narrow_cells = 1; cell_h_m1 = 15;
    start_hi = 8'h40; start_lo = 0; curs_hi = 8'h40; curs_lo = 0;
    curs_top = 6'h00; curs_bot = 5'h1F;
    plant(0, 0, 16'h1E00, 0, 8'h00);
    px("R8", 3, 2); px("R2", 9, 2); px("R2", 12, 40);
    drain();
    start_hi = 0; curs_hi = 0; curs_lo = 5; curs_top = 6'h0E; curs_bot = 15;

    // R9: active area edges
    cols_m1 = 9;
    px("R9", 79, 10); px("R9", 80, 10); px("R9", 399, 10);
    px("R9", 5, 399); px("R9", 5, 400);
    drain();
    vde_hi = 2'b10; vde_lo = 0;
    px("R9", 5, 511); px("R9", 5, 512);
    drain();
    narrow_cells = 0;
    px("R9", 89, 30); px("R9", 90, 30);
    drain();
    narrow_cells = 1; cols_m1 = 79; vde_hi = 2'b01; vde_lo = 8'h8F;

    // R10: display off, then on again
    display_en = 0;
    for (int x = 0; x < 6; x++) px("R10", x * 13, 50);
    drain();
    display_en = 1;
    px("R10", 13, 50);
    drain();

    summary();
    $finish;
  end
endmodule